// File: doc/BRIEF.md
# Multi-Lane Frame-Aligned Deskew Buffer

This receive-side block takes eight 32-bit lanes on one common clock. Each lane carries its own frame pulse and payload-envelope flag. It removes the skew between the lanes of an alignment group, so that every lane of that group delivers the word that carried its frame pulse in the same cycle. After that first word, all lanes of the group keep moving in lockstep. A group is either a pair of neighbouring lanes (four groups) or all eight lanes together. A small circular buffer per lane holds the early lanes until the latest lane of the group has shown its frame pulse.

Any lane can be switched to pass-through. A pass-through lane leaves its group, skips the buffer and appears one cycle later. A group whose skew is too large raises an error flag on its lanes and delivers nothing. Changing the grouping flushes every lane and starts alignment again from the frame pulses that follow.

Top module: `lane_deskew`

## Requirements
- R1: Each lane carries a 32-bit word, a frame-pulse bit and a payload-envelope bit. On a valid aligned output, all three belong to the same input word of that lane's own stream, delivered in input order without gaps.
- R2: With `grp_mode` = 0, lanes 2k and 2k+1 form group k (k = 0..3). Each group aligns independently of the others.
- R3: With `grp_mode` = 1, all non-pass-through lanes form a single group.
- R4: Let T be the clock edge that captures the frame pulse of the last member of a group to show one. After edge T+1, every member raises `out_valid` and presents its own frame-pulse word. Every later cycle presents the next word of each lane.
- R5: A skew of up to 12 cycles between the first and the last member frame pulse is accepted, including exactly 12.
- R6: If 12 cycles pass after the first member frame pulse and some member has still shown none, the group's lanes raise `align_err` after that edge. They keep `out_valid` low, and `align_err` stays high until the group aligns or is flushed.
- R7: A lane with its `lane_bypass` bit set outputs its input word, frame-pulse bit and envelope bit one cycle later with `out_valid` high. It takes no part in any group, and its `align_err` is 0.
- R8: A change of `grp_mode` clears every lane, so all `out_valid` bits are low after that edge. Alignment then restarts from frame pulses captured on later edges.
- R9: During and just after reset, `out_valid` and `align_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_mode | input | 1 | 0 = four pairs, 1 = one group of eight |
| lane_bypass | input | 8 | Per-lane pass-through select |
| in_data | input | 256 | Lane i word at bits [32i+31:32i] |
| in_fp | input | 8 | Per-lane frame pulse |
| in_spe | input | 8 | Per-lane payload-envelope flag |
| out_data | output | 256 | Aligned lane words, same packing as in_data |
| out_fp | output | 8 | Frame pulse travelling with each output word |
| out_spe | output | 8 | Envelope flag travelling with each output word |
| out_valid | output | 8 | Per-lane output valid |
| align_err | output | 8 | Per-lane flag: its group exceeded the skew limit |

## Verification
The hardest state to reach from the ports is a group that keeps failing. After each error the group clears, so it hunts again from whichever pulse comes next. The frames therefore have to repeat, with the skew set so that no later pairing of pulses falls within the limit either. The stimulus uses a 32-cycle frame with skews of 13 and 14. Every re-hunt then still sees a gap of at least 13, so the error must persist for the whole run. Skews of exactly 12 and 13 probe the limit from both sides. Each scenario is entered through a grouping change, so that every one of them also covers the flush.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
    localparam int LANES   = 8;
    localparam int DW      = 32;
    localparam int NGROUPS = LANES / 2;
    localparam int GW      = $clog2(NGROUPS);

    typedef struct packed {
        logic          fp;
        logic          spe;
        logic [DW-1:0] data;
    } word_t;

    typedef enum logic {
        G_HUNT = 1'b0,
        G_RUN  = 1'b1
    } gstate_e;

    // group index of a lane: pairs in mode 0, everything in group 0 in mode 1
    function automatic logic [GW-1:0] group_of(input logic all_mode, input int lane);
        return all_mode ? '0 : GW'(lane / 2);
    endfunction
endpackage

// File: rtl/deskew_lane.sv
module deskew_lane
    import deskew_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  bypass,
    input  word_t in_w,
    input  logic  grp_start,
    input  logic  grp_clear,
    input  logic  grp_run,
    output logic  seen_now,
    output word_t out_w,
    output logic  out_vld
);
    localparam int PW = $clog2(DEPTH);

    word_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, fp_ptr;
    logic          seen;
    logic          hit;

    assign hit      = in_w.fp & ~bypass;
    assign seen_now = seen | hit;

    always_ff @(posedge clk) begin
        if (!rst && !flush) mem[wr_ptr] <= in_w;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fp_ptr  <= '0;
            seen    <= 1'b0;
            out_w   <= '0;
            out_vld <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + PW'(1);
            if (grp_clear) begin
                seen <= 1'b0;
            end else if (!seen && hit) begin
                seen   <= 1'b1;
                fp_ptr <= wr_ptr;
            end
            if (grp_start)    rd_ptr <= seen ? fp_ptr : wr_ptr;
            else if (grp_run) rd_ptr <= rd_ptr + PW'(1);
            if (bypass) begin
                out_w   <= in_w;
                out_vld <= 1'b1;
            end else if (grp_run) begin
                out_w   <= mem[rd_ptr];
                out_vld <= 1'b1;
            end else begin
                out_w   <= '0;
                out_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/deskew_group.sv
module deskew_group #(
    parameter int LANES    = 8,
    parameter int MAX_SKEW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [LANES-1:0] mask,
    input  logic [LANES-1:0] seen_now,
    output logic             start,
    output logic             clear,
    output logic             run,
    output logic             err
);
    import deskew_pkg::*;
    localparam int CW = $clog2(MAX_SKEW + 1);

    gstate_e       state;
    logic [CW-1:0] cnt;
    logic          all_in, any_in, limit;

    assign all_in = (|mask) && (&(seen_now | ~mask));
    assign any_in = |(seen_now & mask);
    assign limit  = (cnt == CW'(MAX_SKEW));
    assign start  = (state == G_HUNT) && all_in;
    assign clear  = (state == G_HUNT) && !all_in && any_in && limit;
    assign run    = (state == G_RUN);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= G_HUNT;
            cnt   <= '0;
            err   <= 1'b0;
        end else if (state == G_HUNT) begin
            if (all_in) begin
                state <= G_RUN;
                cnt   <= '0;
                err   <= 1'b0;
            end else if (any_in) begin
                if (limit) begin
                    cnt <= '0;
                    err <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import deskew_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int MAX_SKEW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grp_mode,
    input  logic [LANES-1:0]  lane_bypass,
    input  logic [LANES*DW-1:0] in_data,
    input  logic [LANES-1:0]  in_fp,
    input  logic [LANES-1:0]  in_spe,
    output logic [LANES*DW-1:0] out_data,
    output logic [LANES-1:0]  out_fp,
    output logic [LANES-1:0]  out_spe,
    output logic [LANES-1:0]  out_valid,
    output logic [LANES-1:0]  align_err
);
    logic                          mode_q;
    logic                          flush;
    logic [GW-1:0]                 lane_grp [LANES];
    logic [NGROUPS-1:0][LANES-1:0] grp_mask;
    logic [NGROUPS-1:0]            g_start, g_clear, g_run, g_err;
    logic [LANES-1:0]              seen_now, l_start, l_clear, l_run, l_vld;
    word_t                         in_w  [LANES];
    word_t                         out_w [LANES];

    always_ff @(posedge clk) begin
        mode_q <= grp_mode;
    end
    assign flush = !rst && (grp_mode != mode_q);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_grp[i]  = group_of(grp_mode, i);
            in_w[i].fp   = in_fp[i];
            in_w[i].spe  = in_spe[i];
            in_w[i].data = in_data[i*DW +: DW];
        end
        for (int g = 0; g < NGROUPS; g++)
            for (int i = 0; i < LANES; i++)
                grp_mask[g][i] = !lane_bypass[i] && (lane_grp[i] == GW'(g));
        for (int i = 0; i < LANES; i++) begin
            l_start[i]            = g_start[lane_grp[i]];
            l_clear[i]            = g_clear[lane_grp[i]];
            l_run[i]              = g_run[lane_grp[i]];
            align_err[i]          = !lane_bypass[i] && g_err[lane_grp[i]];
            out_data[i*DW +: DW]  = out_w[i].data;
            out_fp[i]             = out_w[i].fp;
            out_spe[i]            = out_w[i].spe;
        end
    end
    assign out_valid = l_vld;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        deskew_group #(.LANES(LANES), .MAX_SKEW(MAX_SKEW)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .mask     (grp_mask[g]),
            .seen_now (seen_now),
            .start    (g_start[g]),
            .clear    (g_clear[g]),
            .run      (g_run[g]),
            .err      (g_err[g])
        );
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        deskew_lane #(.DEPTH(DEPTH)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .bypass    (lane_bypass[i]),
            .in_w      (in_w[i]),
            .grp_start (l_start[i]),
            .grp_clear (l_clear[i]),
            .grp_run   (l_run[i]),
            .seen_now  (seen_now[i]),
            .out_w     (out_w[i]),
            .out_vld   (l_vld[i])
        );
    end
endmodule

// File: rtl/deskew_checker.sv
module deskew_checker #(
    parameter int LANES = 8,
    parameter int DW    = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               grp_mode,
    input logic [LANES-1:0]   lane_bypass,
    input logic [LANES*DW-1:0] in_data,
    input logic [LANES-1:0]   out_valid,
    input logic [LANES-1:0]   align_err,
    input logic [LANES*DW-1:0] out_data
);
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_valid == '0 && align_err == '0));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (out_valid == '0));

    for (genvar i = 0; i < LANES; i++) begin : g_l
        assert_bypass_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
            (lane_bypass[i] && !flush) |=>
                (out_valid[i] && out_data[i*DW +: DW] == $past(in_data[i*DW +: DW])));

        assert_err_blocks_valid_R6: assert property (@(posedge clk) disable iff (rst)
            (align_err[i] && $stable(lane_bypass[i]) && $stable(grp_mode)) |-> !out_valid[i]);
    end

    for (genvar p = 0; p < LANES / 2; p++) begin : g_p
        assert_pair_valid_together_R2: assert property (@(posedge clk) disable iff (rst)
            (!lane_bypass[2*p] && !lane_bypass[2*p+1] && !flush) |=>
                (out_valid[2*p] == out_valid[2*p+1]));
    end
endmodule

bind lane_deskew deskew_checker #(.LANES(deskew_pkg::LANES), .DW(deskew_pkg::DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .grp_mode    (grp_mode),
    .lane_bypass (lane_bypass),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .align_err   (align_err),
    .out_data    (out_data)
);

// File: tb/test_lane_deskew.sv
module test_lane_deskew;
    localparam int L = 8;
    localparam int W = 32;
    localparam int P = 32;      // frame period in words
    localparam int LIMIT = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             grp_mode = 1'b0;
    logic [L-1:0]     lane_bypass = '0;
    logic [L*W-1:0]   in_data = '0;
    logic [L-1:0]     in_fp = '0, in_spe = '0;
    logic [L*W-1:0]   out_data;
    logic [L-1:0]     out_fp, out_spe, out_valid, align_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int s_base = 0;
    int off [L];
    string tag = "";

    typedef struct {
        logic [L-1:0]   vld;
        logic [L-1:0]   err;
        logic [L-1:0]   byp;
        logic [L*W-1:0] data;
        logic [L-1:0]   fp;
        logic [L-1:0]   spe;
        string          tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    lane_deskew i_lane_deskew (
        .clk(clk), .rst(rst), .grp_mode(grp_mode), .lane_bypass(lane_bypass),
        .in_data(in_data), .in_fp(in_fp), .in_spe(in_spe),
        .out_data(out_data), .out_fp(out_fp), .out_spe(out_spe),
        .out_valid(out_valid), .align_err(align_err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] sdata(int i, int pos);
        return {8'(i), 24'(pos)};
    endfunction
    function automatic logic sfp(int pos);
        return pos >= 0 && (pos % P) == 0;
    endfunction
    function automatic logic sspe(int pos);
        return pos >= 0 && (pos % P) >= 4;
    endfunction

    task automatic check(input string t, input string what, input int lane,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s lane %0d %s got %h expected %h", t, lane, what, got, exp);
        end
    endtask

    // drive inputs for the coming edge n and queue the outputs expected after it
    task automatic step();
        exp_t x;
        int   n = cyc + 1;
        for (int i = 0; i < L; i++) begin
            int pos = n - s_base - off[i];
            in_data[i*W +: W] = sdata(i, pos);
            in_fp[i]  = sfp(pos);
            in_spe[i] = sspe(pos);
        end
        x.tag = tag;
        x.byp = lane_bypass;
        for (int i = 0; i < L; i++) begin
            int mx = -1000, mn = 1000, pos;
            for (int j = 0; j < L; j++) begin
                if (!lane_bypass[j] && (grp_mode || (j / 2 == i / 2))) begin
                    if (off[j] > mx) mx = off[j];
                    if (off[j] < mn) mn = off[j];
                end
            end
            if (lane_bypass[i]) begin
                pos = n - s_base - off[i];
                x.vld[i] = n >= s_base;
                x.err[i] = 1'b0;
            end else if (mx - mn <= LIMIT) begin
                pos = n - 1 - s_base - mx;
                x.vld[i] = n >= s_base + mx + 1;
                x.err[i] = 1'b0;
            end else begin
                pos = 0;
                x.vld[i] = 1'b0;
                x.err[i] = n >= s_base + mn + LIMIT;
            end
            x.data[i*W +: W] = sdata(i, pos);
            x.fp[i]  = sfp(pos);
            x.spe[i] = sspe(pos);
        end
        q.push_back(x);
        @(negedge clk);
    endtask

    task automatic scenario(input logic mode, input logic [L-1:0] byp,
                            input int o0, input int o1, input int o2, input int o3,
                            input int o4, input int o5, input int o6, input int o7,
                            input string t, input int len);
        grp_mode = mode;
        lane_bypass = byp;
        off = '{o0, o1, o2, o3, o4, o5, o6, o7};
        tag = t;
        s_base = cyc + 2;   // grouping change flushes on the next edge
        repeat (len) step();
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (q.size() != 0) begin
            e = q.pop_front();
            for (int i = 0; i < L; i++) begin
                check(e.byp[i] ? {e.tag, " R7"} : e.tag, "valid", i,
                      W'(out_valid[i]), W'(e.vld[i]));
                check("R6", "align_err", i, W'(align_err[i]), W'(e.err[i]));
                if (e.vld[i]) begin
                    check("R1", "data", i, out_data[i*W +: W], e.data[i*W +: W]);
                    check("R1", "frame pulse", i, W'(out_fp[i]), W'(e.fp[i]));
                    check("R1", "envelope", i, W'(out_spe[i]), W'(e.spe[i]));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        off = '{0, 0, 0, 0, 0, 0, 0, 0};
        repeat (3) @(negedge clk);
        check("R9", "valid in reset", 0, W'(out_valid), W'(0));
        check("R9", "align_err in reset", 0, W'(align_err), W'(0));
        // pairs with skews 3, 0, 12 (limit) and 7
        off = '{0, 3, 5, 5, 12, 0, 2, 9};
        tag = "R2 R4 R5 R9";
        s_base = cyc + 1;
        rst = 1'b0;
        repeat (90) step();
        // one group of eight, skew 11
        scenario(1'b1, 8'h00, 4, 0, 7, 11, 2, 9, 1, 6, "R3 R4 R8", 80);
        // pairs: group 0 skew 14 fails, lane 3 passes through, lane 2 aligns alone
        scenario(1'b0, 8'h08, 0, 14, 0, 20, 1, 2, 3, 3, "R2 R6 R8", 100);
        // one group with lanes 0 and 7 passing through, member skew 10
        scenario(1'b1, 8'h81, 0, 2, 8, 5, 0, 10, 4, 0, "R3 R7 R8", 80);
        // pairs: skew 13, just over the limit
        scenario(1'b0, 8'h00, 0, 13, 1, 1, 6, 2, 0, 0, "R5 R6 R8", 80);
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule